// File: doc/BRIEF.md
# DRAM Power-Down Sequencer

This block sits on the controller side of a DDR3-style memory interface and owns the clock-enable line. On request it takes the memory into power-down by driving clock-enable low. It keeps the line low for at least the programmed minimum. It brings the line back high either on a wake request or, if no wake arrives, on its own before the maximum power-down time runs out. During exit it drives a no-operation on its command slot and holds that line high for at least the programmed minimum.

After an exit, two registered flags tell the command arbiter what it may issue. `gen_rdy` allows ordinary commands. `dll_rdy` allows commands that need a locked DLL: reads, reads with auto-precharge, and turning on termination. The exit is fast when a bank was open at entry, or when all banks were precharged with the DLL kept running. In both fast cases `dll_rdy` follows `gen_rdy`. The exit is slow when all banks were precharged with the DLL frozen, and then `dll_rdy` waits for the longer DLL exit time.

A refresh requested around an exit is issued on the command slot once ordinary commands are allowed. A new power-down is not entered until the DLL exit time has passed since the last exit. Every timing value is a cycle-count input, so one build serves several speed grades.

Top module: `dram_pd_seq`

## Requirements
- R1: While `rst_n` is low, `cke` is 0, `cmd` is DES (2'b00) and both ready flags are 0. In the first cycle after release, `cke` is 1 and `cmd` is NOP (2'b01). Both flags then rise `max(t_xp,1)` cycles after that first high cycle.
- R2: With no exit timer running, a `pd_req` seen at a clock edge drives `cke` low in the following cycle. A one-cycle `pd_req` that arrives while a timer still runs is held pending and taken as soon as the timers allow.
- R3: `cke` stays low for at least `t_pd` cycles (`t_pd` ≥ 1). A `wake_req` present earlier is deferred until then, and with `wake_req` held from the first low cycle, the low time is exactly `t_pd` cycles.
- R4: Without any wake, `cke` returns high on its own after exactly `9*t_refi-1` low cycles, so power-down never reaches nine refresh intervals. This assumes `t_pd < 9*t_refi`.
- R5: While `cke` is low, `cmd` shows DES. In the first cycle `cke` is high again, `cmd` shows NOP and both ready flags are 0.
- R6: If `bank_open` was 1 at entry, both flags rise `max(t_xp,1)` cycles after the first high cycle, whatever `dll_fast` is.
- R7: If `bank_open` was 0 and `dll_fast` was 1 at entry, both flags rise `max(t_xp,1)` cycles after the first high cycle.
- R8: If `bank_open` was 0 and `dll_fast` was 0 at entry, `gen_rdy` rises after `max(t_xp,1)` cycles and `dll_rdy` after `max(t_xpdll,1)` cycles. Both inputs are sampled only at the entry edge; changing them during power-down has no effect.
- R9: After an exit, `cke` stays high for at least `t_cke` cycles before the next entry.
- R10: The next entry comes no earlier than `max(t_xpdll,1)+1` cycles after the first high cycle, and also waits for the `t_xp` timer.
- R11: A `ref_req` pulse is held until `gen_rdy` is high. It then appears as a single REFRESH (2'b10) in the next cycle, and it blocks power-down entry until it has been issued.
- R12: Pulling `rst_n` low during power-down at once gives the reset values of R1, and release restarts as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, kept running during power-down |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| bank_open | input | 1 | 1 when any bank is open |
| dll_fast | input | 1 | Mode-register DLL control bit: 1 keeps the DLL running in precharged power-down |
| ref_req | input | 1 | Refresh request pulse |
| t_pd | input | CW | Minimum low time of clock-enable, cycles |
| t_cke | input | CW | Minimum high time of clock-enable, cycles |
| t_xp | input | CW | Exit to ordinary command, cycles |
| t_xpdll | input | CW | Exit to DLL-dependent command, cycles |
| t_refi | input | RW | Refresh interval, cycles |
| cke | output | 1 | Clock-enable to the memory |
| cmd | output | 2 | Command slot: 00 DES, 01 NOP, 10 REFRESH |
| gen_rdy | output | 1 | Ordinary commands may be issued |
| dll_rdy | output | 1 | DLL-dependent commands may be issued |

## Verification
The hardest case to reach is a refresh squeezed between an exit and the next entry. Here three timers are running at once, and the refresh must wait for the ordinary-command timer while entry waits for the DLL timer. The bench gets there by pulsing the refresh request in the very exit cycle, or by pulsing a power-down request there, so that the request has to wait as a pending request. It then counts cycles from the first high cycle to the REFRESH or to the next low cycle. Changing the bank and DLL inputs straight after entry shows that the exit type was fixed at entry.

// File: rtl/dram_pd_seq.sv
module dram_pd_seq #(
  parameter int CW = 8,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_req,
  input  logic          wake_req,
  input  logic          bank_open,
  input  logic          dll_fast,
  input  logic          ref_req,
  input  logic [CW-1:0] t_pd,
  input  logic [CW-1:0] t_cke,
  input  logic [CW-1:0] t_xp,
  input  logic [CW-1:0] t_xpdll,
  input  logic [RW-1:0] t_refi,
  output logic          cke,
  output logic [1:0]    cmd,
  output logic          gen_rdy,
  output logic          dll_rdy
);
  localparam int DW = RW + 4;
  localparam logic [1:0] CMD_DES = 2'b00;
  localparam logic [1:0] CMD_NOP = 2'b01;
  localparam logic [1:0] CMD_REF = 2'b10;

  typedef enum logic [1:0] {S_RST, S_UP, S_PD} st_t;

  st_t st_q, st_n;
  logic cke_q, cke_n, gen_q, gen_n, dll_q, dll_n;
  logic slow_q, slow_n, pdp_q, pdp_n, refp_q, refp_n;
  logic [1:0] cmd_q, cmd_n;
  logic [CW-1:0] pd_q, pd_n, ck_q, ck_n, xp_q, xp_n, xd_q, xd_n;
  logic [DW-1:0] dur_q, dur_n, nine_refi, dur_load;
  logic ref_want, pd_want, timers_idle, ref_go, do_enter, do_exit;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - CW'(1);
  endfunction

  function automatic logic [CW-1:0] atleast1(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  assign nine_refi   = DW'(t_refi) * DW'(9);
  assign dur_load    = (nine_refi < DW'(2)) ? '0 : nine_refi - DW'(2);
  assign ref_want    = ref_req | refp_q;
  assign pd_want     = pd_req | pdp_q;
  assign timers_idle = (xp_q == '0) && (xd_q == '0) && (ck_q == '0);
  assign ref_go      = (st_q == S_UP) && ref_want && gen_q;
  assign do_enter    = (st_q == S_UP) && pd_want && !ref_want && timers_idle;
  assign do_exit     = (st_q == S_RST) ||
                       ((st_q == S_PD) && (pd_q == '0) && (wake_req || dur_q == '0));

  always_comb begin
    st_n   = st_q;
    cke_n  = cke_q;
    cmd_n  = CMD_DES;
    slow_n = slow_q;
    pd_n   = dec(pd_q);
    ck_n   = dec(ck_q);
    xp_n   = dec(xp_q);
    xd_n   = dec(xd_q);
    dur_n  = (dur_q == '0) ? '0 : dur_q - DW'(1);
    refp_n = ref_want && !ref_go;
    pdp_n  = (st_q == S_UP) && pd_want && !do_enter;
    if (do_exit) begin
      st_n  = S_UP;
      cke_n = 1'b1;
      cmd_n = CMD_NOP;
      ck_n  = dec(t_cke);
      xp_n  = atleast1(t_xp);
      xd_n  = atleast1(t_xpdll);
      if (st_q == S_RST) slow_n = 1'b0;
    end else if (do_enter) begin
      st_n   = S_PD;
      cke_n  = 1'b0;
      pd_n   = dec(t_pd);
      dur_n  = dur_load;
      slow_n = !bank_open && !dll_fast;
    end
    if (ref_go) cmd_n = CMD_REF;
    gen_n = (st_n == S_UP) && (xp_n == '0);
    dll_n = (st_n == S_UP) && (slow_n ? (xd_n == '0) : (xp_n == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_RST;
      cke_q  <= 1'b0;
      cmd_q  <= CMD_DES;
      gen_q  <= 1'b0;
      dll_q  <= 1'b0;
      slow_q <= 1'b0;
      pdp_q  <= 1'b0;
      refp_q <= 1'b0;
      pd_q   <= '0;
      ck_q   <= '0;
      xp_q   <= '0;
      xd_q   <= '0;
      dur_q  <= '0;
    end else begin
      st_q   <= st_n;
      cke_q  <= cke_n;
      cmd_q  <= cmd_n;
      gen_q  <= gen_n;
      dll_q  <= dll_n;
      slow_q <= slow_n;
      pdp_q  <= pdp_n;
      refp_q <= refp_n;
      pd_q   <= pd_n;
      ck_q   <= ck_n;
      xp_q   <= xp_n;
      xd_q   <= xd_n;
      dur_q  <= dur_n;
    end
  end

  assign cke     = cke_q;
  assign cmd     = cmd_q;
  assign gen_rdy = gen_q;
  assign dll_rdy = dll_q;

  // run-length counters for the timing assertions
  logic [DW-1:0] low_run, high_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= cke_n ? '0 : ((&low_run) ? low_run : low_run + DW'(1));
      high_run <= !cke_n ? '0 : ((&high_run) ? high_run : high_run + DW'(1));
    end
  end

  p_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PD && cke_n) |-> (low_run >= DW'(t_pd)));

  p_max_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PD) |-> (low_run < nine_refi));

  p_exit_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_q) |-> (cmd_q == CMD_NOP && !gen_q && !dll_q));

  p_low_des_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> (cmd_q == CMD_DES && !gen_q && !dll_q));

  p_min_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && !cke_n) |-> (high_run >= DW'(t_cke)));

  p_ref_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> $past(gen_q));

  p_ref_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |=> (cmd_q != CMD_REF));
endmodule

// File: tb/dram_pd_seq_bench.sv
module dram_pd_seq_bench;
  localparam int CW = 8;
  localparam int RW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, wake_req = 1'b0, bank_open = 1'b0, dll_fast = 1'b0, ref_req = 1'b0;
  logic [CW-1:0] t_pd = 8'd3, t_cke = 8'd4, t_xp = 8'd5, t_xpdll = 8'd12;
  logic [RW-1:0] t_refi = 12'd4;
  logic cke, gen_rdy, dll_rdy;
  logic [1:0] cmd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_pd_seq #(.CW(CW), .RW(RW)) u_dram_pd_seq (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_req(wake_req),
    .bank_open(bank_open), .dll_fast(dll_fast), .ref_req(ref_req),
    .t_pd(t_pd), .t_cke(t_cke), .t_xp(t_xp), .t_xpdll(t_xpdll), .t_refi(t_refi),
    .cke(cke), .cmd(cmd), .gen_rdy(gen_rdy), .dll_rdy(dll_rdy));

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic settle;
    repeat (20) step();
  endtask

  task automatic enter(input logic b, input logic d);
    int n;
    bank_open = b;
    dll_fast = d;
    pd_req = 1'b1;
    n = 0;
    do begin step(); n++; end while (cke !== 1'b0 && n < 100);
    pd_req = 1'b0;
    bank_open = !b;
    dll_fast = !d;
    chk("R2 entry delay", n, 1);
  endtask

  task automatic wake_out(output int low);
    wake_req = 1'b1;
    low = 1;
    forever begin
      step();
      if (cke === 1'b0 && low < 200) low++;
      else break;
    end
    wake_req = 1'b0;
  endtask

  task automatic exit_flags(input string r, input int eg, input int ed);
    int mg, md, m;
    chk("R5 exit cmd NOP", int'(cmd), 1);
    chk("R5 exit gen_rdy low", int'(gen_rdy), 0);
    chk("R5 exit dll_rdy low", int'(dll_rdy), 0);
    mg = -1; md = -1; m = 0;
    while ((mg < 0 || md < 0) && m < 100) begin
      step();
      m++;
      if (gen_rdy === 1'b1 && mg < 0) mg = m;
      if (dll_rdy === 1'b1 && md < 0) md = m;
    end
    chk({r, " gen_rdy delay"}, mg, eg);
    chk({r, " dll_rdy delay"}, md, ed);
  endtask

  task automatic s_reset_init;
    step();
    chk("R1 reset cke", int'(cke), 0);
    chk("R1 reset cmd", int'(cmd), 0);
    chk("R1 reset gen_rdy", int'(gen_rdy), 0);
    chk("R1 reset dll_rdy", int'(dll_rdy), 0);
    rst_n = 1'b1;
    step();
    chk("R1 cke after release", int'(cke), 1);
    exit_flags("R1", 5, 5);
    settle();
  endtask

  task automatic s_active;
    int low;
    enter(1'b1, 1'b0);
    wake_out(low);
    chk("R3 low time with early wake", low, 3);
    exit_flags("R6", 5, 5);
    settle();
  endtask

  task automatic s_dll_on;
    int low;
    enter(1'b0, 1'b1);
    wake_out(low);
    exit_flags("R7", 5, 5);
    settle();
  endtask

  task automatic s_slow;
    int low;
    enter(1'b0, 1'b0);
    wake_out(low);
    exit_flags("R8", 5, 12);
    settle();
  endtask

  task automatic s_max;
    int low, bad;
    enter(1'b1, 1'b1);
    low = 1; bad = 0;
    if (cmd !== 2'b00) bad++;
    forever begin
      step();
      if (cke === 1'b0 && low < 200) begin
        low++;
        if (cmd !== 2'b00) bad++;
      end else break;
    end
    chk("R4 forced exit low time", low, 35);
    chk("R5 DES while low", bad, 0);
    settle();
  endtask

  task automatic s_reentry(input string r, input int exp);
    int low, n;
    enter(1'b1, 1'b1);
    wake_out(low);
    pd_req = 1'b1;
    step();
    pd_req = 1'b0;
    n = 1;
    while (cke !== 1'b0 && n < 200) begin step(); n++; end
    chk(r, n, exp);
    wake_out(low);
    settle();
  endtask

  task automatic s_refresh;
    int low, n;
    enter(1'b1, 1'b1);
    wake_out(low);
    ref_req = 1'b1;
    step();
    ref_req = 1'b0;
    n = 1;
    while (cmd !== 2'b10 && n < 200) begin step(); n++; end
    chk("R11 refresh slot", n, 6);
    step();
    chk("R11 single refresh", int'(cmd), 0);
    settle();
  endtask

  task automatic s_reset_pd;
    enter(1'b0, 1'b0);
    step();
    step();
    rst_n = 1'b0;
    #2;
    chk("R12 cke in reset", int'(cke), 0);
    chk("R12 cmd in reset", int'(cmd), 0);
    chk("R12 flags in reset", int'(gen_rdy) + int'(dll_rdy), 0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R12 cke after release", int'(cke), 1);
    exit_flags("R12", 5, 5);
    settle();
  endtask

  initial begin
    s_reset_init();
    s_active();
    s_dll_on();
    s_slow();
    s_max();
    s_reentry("R10 pending re-entry delay", 13);
    t_cke = 8'd20;
    s_reentry("R9 re-entry held by t_cke", 20);
    t_cke = 8'd4;
    s_refresh();
    s_reset_pd();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule